// File: doc/BRIEF.md
# Inter-Core Doorbell Register Bank

This block is a small memory-mapped register bank that lets any bus master signal any one of eight processor cores. Each core owns two registers: a ring register and a clear register. Writing the ring register records software-defined source flags for that core, and can also fire a one-cycle interrupt toward it. The core's handler reads the flags back and writes the ones it has serviced to its clear register.

Every write to the ring and clear registers is protected by a two-key unlock. The bank only accepts such writes while two separate key registers both hold their fixed key constants. A clear written while the bank is locked is dropped, so the flags stay pending. The block models the effect of that mistake: once a core has been rung, its next clear-register write is followed by a check, and if flags remain set the core is interrupted a second time.

The bus port is a single-cycle register interface. A write takes effect at the clock edge where `busWrEn` is high. Read data is combinational from `busAddr`.

Top module: `doorbell_bank`

## Requirements
- R1: After reset all source flags read as zero, every `coreIrq` bit is low, and the bank is locked.
- R2: The ring register of core x is at byte offset 0x240 + 4x and its clear register is at 0x280 + 4x (x = 0..7, word aligned). Reading either one returns core x's source flags in bits 31:4, with bits 3:0 reading zero.
- R3: An accepted ring write sets every flag in bits 31:4 whose data bit is 1 and leaves the other flags unchanged. Data bits 3:1 are reserved and have no effect.
- R4: An accepted ring write with data bit 0 set drives `coreIrq[x]` high for exactly the one cycle after the write edge, and no other core's interrupt. Bit 0 is never stored.
- R5: An accepted clear write to core x clears every flag of core x whose data bit in 31:4 is 1 and leaves the rest unchanged.
- R6: The bank is unlocked only while the key register at offset 0x038 holds 0xC0DE5A17 and the key register at offset 0x03C holds 0x7E11B00F. While it is locked, ring and clear writes change no flag and raise no interrupt.
- R7: Writing any value other than its key to either key register locks the bank again.
- R8: After core x has been rung, its next clear-register write, whether or not the bank is locked, is followed one cycle later by a single extra `coreIrq[x]` pulse if any of its flags are still set, and by no pulse if none are. Later clear writes cause no further pulse until the core is rung again.
- R9: Writes to any other address change nothing, and reads of any other address, the key registers included, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busAddr | input | 12 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| coreIrq | output | 8 | One interrupt pulse line per core |

## Verification
The bench goes after a clear that is dropped because the bank is locked. A design that honoured that clear would lose the second interrupt, and one that re-armed after the extra pulse would keep firing on every later clear. The bench also relocks the bank with a wrong key in either key register. A design that latched the unlock state instead of comparing both keys would still accept writes. Other cases it checks are ring writes carrying only bit 0 or only reserved bits, back-to-back rings, and misaligned or out-of-range addresses. A design that stored bit 0 or the reserved bits, or aliased nearby addresses onto the registers, would return wrong read data or pulse the wrong core.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int NCORE    = 8;
  localparam int DW       = 32;
  localparam int AW       = 12;
  localparam int FLAG_LSB = 4;
  localparam int CIDX_W   = $clog2(NCORE);

  localparam logic [AW-1:0] RING_BASE = AW'('h240);
  localparam logic [AW-1:0] CLR_BASE  = AW'('h280);
  localparam logic [AW-1:0] KEYA_OFS  = AW'('h038);
  localparam logic [AW-1:0] KEYB_OFS  = AW'('h03C);
  localparam logic [AW-1:0] SPAN      = AW'(4 * NCORE);

  localparam logic [DW-1:0] KEYA_VAL  = 32'hC0DE_5A17;
  localparam logic [DW-1:0] KEYB_VAL  = 32'h7E11_B00F;
  localparam logic [DW-1:0] FLAG_MASK = {{(DW-FLAG_LSB){1'b1}}, {FLAG_LSB{1'b0}}};

  typedef struct packed {
    logic [NCORE-1:0]  setOh;      // accepted ring write, per core
    logic [NCORE-1:0]  clrOh;      // accepted clear write, per core
    logic [NCORE-1:0]  clrTouchOh; // any clear write, locked or not
    logic              ringBit;    // data bit 0 of the write
    logic [DW-1:0]     wrFlags;    // write data restricted to flag bits
    logic              rdHit;      // read address selects a core register
    logic [CIDX_W-1:0] rdIdx;      // core selected by the read address
  } strobe_t;
endpackage

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWrData,
  output strobe_t       strb
);
  logic [DW-1:0]     keyAQ, keyBQ;
  logic              unlocked;
  logic [AW-1:0]     ringOff, clrOff;
  logic              ringHit, clrHit;
  logic [CIDX_W-1:0] ringIdx, clrIdx;

  assign unlocked = (keyAQ == KEYA_VAL) && (keyBQ == KEYB_VAL);

  assign ringOff = busAddr - RING_BASE;
  assign clrOff  = busAddr - CLR_BASE;
  assign ringHit = (ringOff < SPAN) && (ringOff[1:0] == 2'b00);
  assign clrHit  = (clrOff  < SPAN) && (clrOff[1:0]  == 2'b00);
  assign ringIdx = ringOff[CIDX_W+1:2];
  assign clrIdx  = clrOff[CIDX_W+1:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyAQ <= '0;
      keyBQ <= '0;
    end else if (busWrEn) begin
      if (busAddr == KEYA_OFS) keyAQ <= busWrData;
      if (busAddr == KEYB_OFS) keyBQ <= busWrData;
    end
  end

  always_comb begin
    strb = '0;
    for (int i = 0; i < NCORE; i++) begin
      strb.setOh[i]      = busWrEn && unlocked && ringHit && (ringIdx == CIDX_W'(i));
      strb.clrOh[i]      = busWrEn && unlocked && clrHit  && (clrIdx  == CIDX_W'(i));
      strb.clrTouchOh[i] = busWrEn && clrHit && (clrIdx == CIDX_W'(i));
    end
    strb.ringBit = busWrData[0];
    strb.wrFlags = busWrData & FLAG_MASK;
    strb.rdHit   = ringHit || clrHit;
    strb.rdIdx   = ringHit ? ringIdx : clrIdx;
  end

  // R6: unlocking only ever follows a write to a key register
  assert_unlock_needs_key_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> ($past(busWrEn) &&
      (($past(busAddr) == KEYA_OFS) || ($past(busAddr) == KEYB_OFS))));

  // R7: a wrong value in either key register leaves the bank locked
  assert_wrong_key_locks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (((busAddr == KEYA_OFS) && (busWrData != KEYA_VAL)) ||
                 ((busAddr == KEYB_OFS) && (busWrData != KEYB_VAL))))
    |=> !unlocked);

  // R4: at most one core is targeted by a write
  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.setOh | strb.clrTouchOh));
endmodule

// File: rtl/doorbell_dp.sv
module doorbell_dp
  import doorbell_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic [DW-1:0]    rdData,
  output logic [NCORE-1:0] irq
);
  logic [DW-1:0]    flagsQ [NCORE];
  logic [NCORE-1:0] armedQ, clrSeenQ, irqQ;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    logic ring, repulse;
    logic [DW-1:0] setMask, clrMask;

    assign ring    = strb.setOh[i] && strb.ringBit;
    assign repulse = clrSeenQ[i] && armedQ[i] && (flagsQ[i] != '0);
    assign setMask = strb.setOh[i] ? strb.wrFlags : '0;
    assign clrMask = strb.clrOh[i] ? strb.wrFlags : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagsQ[i]   <= '0;
        armedQ[i]   <= 1'b0;
        clrSeenQ[i] <= 1'b0;
        irqQ[i]     <= 1'b0;
      end else begin
        flagsQ[i]   <= (flagsQ[i] | setMask) & ~clrMask;  // clear wins
        clrSeenQ[i] <= strb.clrTouchOh[i];
        irqQ[i]     <= ring || repulse;
        if (ring)             armedQ[i] <= 1'b1;
        else if (clrSeenQ[i]) armedQ[i] <= 1'b0;
      end
    end

    // R3: a flag set by an accepted ring write is present afterwards
    assert_ring_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.setOh[i] && !strb.clrOh[i]) |=> ((flagsQ[i] & $past(strb.wrFlags)) == $past(strb.wrFlags)));

    // R5: every flag named by an accepted clear write is gone afterwards
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
      strb.clrOh[i] |=> ((flagsQ[i] & $past(strb.wrFlags)) == '0));

    // R6: flags move only on an accepted ring or clear write
    assert_flags_guarded_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.setOh[i] && !strb.clrOh[i]) |=> $stable(flagsQ[i]));

    // R4 and R8: every pulse follows a ring write or a clear-write check
    assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
      irqQ[i] |-> ($past(strb.setOh[i] && strb.ringBit) || $past(clrSeenQ[i])));

    // R3: reserved bits and bit 0 never hold a value
    assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
      flagsQ[i][FLAG_LSB-1:0] == '0);
  end

  assign irq    = irqQ;
  assign rdData = strb.rdHit ? flagsQ[strb.rdIdx] : '0;
endmodule

// File: rtl/doorbell_bank.sv
module doorbell_bank
  import doorbell_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [AW-1:0]    busAddr,
  input  logic [DW-1:0]    busWrData,
  output logic [DW-1:0]    busRdData,
  output logic [NCORE-1:0] coreIrq
);
  strobe_t strb;

  doorbell_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .strb     (strb)
  );

  doorbell_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rdData(busRdData),
    .irq   (coreIrq)
  );
endmodule

// File: tb/doorbell_bank_tb.sv
`timescale 1ns/1ps
module doorbell_bank_tb;
  localparam logic [31:0] KA   = 32'hC0DE_5A17;
  localparam logic [31:0] KB   = 32'h7E11_B00F;
  localparam logic [31:0] MASK = 32'hFFFF_FFF0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  coreIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] mFlags [8];
  bit          mArmed [8];
  bit          mSeen  [8];
  logic [7:0]  mIrq;
  logic [31:0] mKeyA, mKeyB;

  always #10 clk = ~clk;

  doorbell_bank u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .coreIrq(coreIrq)
  );

  function automatic int regIdx(logic [11:0] a, logic [11:0] base);
    logic [11:0] off = a - base;
    if (off < 12'd32 && off[1:0] == 2'b00) return int'(off >> 2);
    return -1;
  endfunction

  function automatic logic [31:0] modelRead(logic [11:0] a);
    int r = regIdx(a, 12'h240);
    int c = regIdx(a, 12'h280);
    if (r >= 0) return mFlags[r];
    if (c >= 0) return mFlags[c];
    return '0;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin
      mFlags[i] = '0; mArmed[i] = 1'b0; mSeen[i] = 1'b0;
    end
    mIrq = '0; mKeyA = '0; mKeyB = '0;
  endtask

  task automatic modelEdge(bit we, logic [11:0] a, logic [31:0] d);
    bit unl = (mKeyA == KA) && (mKeyB == KB);
    bit nSeen [8];
    int r = regIdx(a, 12'h240);
    int c = regIdx(a, 12'h280);
    for (int i = 0; i < 8; i++) begin
      mIrq[i] = mSeen[i] && mArmed[i] && (mFlags[i] != 0);
      if (mSeen[i]) mArmed[i] = 1'b0;
      nSeen[i] = 1'b0;
    end
    if (we) begin
      if (r >= 0 && unl) begin
        mFlags[r] |= d & MASK;
        if (d[0]) begin mIrq[r] = 1'b1; mArmed[r] = 1'b1; end
      end
      if (c >= 0) begin
        nSeen[c] = 1'b1;
        if (unl) mFlags[c] &= ~(d & MASK);
      end
      if (a == 12'h038) mKeyA = d;
      if (a == 12'h03C) mKeyB = d;
    end
    for (int i = 0; i < 8; i++) mSeen[i] = nSeen[i];
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, check read mid-cycle, advance model on the edge, check irq at next negedge
  task automatic step(bit we, logic [11:0] a, logic [31:0] d);
    logic [31:0] expRd;
    busWrEn = we; busAddr = a; busWrData = d;
    #1;
    expRd = modelRead(a);
    check(busRdData === expRd, "R2 R9 read", busRdData, expRd);
    @(posedge clk);
    modelEdge(we, a, d);
    @(negedge clk);
    check(coreIrq === mIrq, "R4 R8 irq", {24'd0, coreIrq}, {24'd0, mIrq});
  endtask

  task automatic unlock();
    step(1'b1, 12'h038, KA);
    step(1'b1, 12'h03C, KB);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check(coreIrq === 8'h00, "R1 irq after reset", {24'd0, coreIrq}, 32'h0);
    for (int i = 0; i < 8; i++) step(1'b0, 12'h240 + 12'(4*i), '0);
    // R1 R6: locked after reset, ring ignored
    step(1'b1, 12'h244, 32'hFFFF_FFFF);
    step(1'b0, 12'h244, '0);
    check(busRdData === 32'h0 && coreIrq === 8'h00, "R1 R6 locked ring", busRdData, 32'h0);

    // R6: one key only is not enough
    step(1'b1, 12'h038, KA);
    step(1'b1, 12'h248, 32'h0000_0101);
    step(1'b0, 12'h248, '0);
    check(busRdData === 32'h0, "R6 half unlock", busRdData, 32'h0);
    step(1'b1, 12'h03C, KB);

    // R3: reserved bits and bit 0 not stored; R4 pulse on one core
    step(1'b1, 12'h248, 32'h0000_000F);
    check(coreIrq === 8'h04, "R4 single pulse", {24'd0, coreIrq}, 32'h4);
    step(1'b0, 12'h248, '0);
    check(busRdData === 32'h0 && coreIrq === 8'h00, "R3 R4 bit0 not stored", busRdData, 32'h0);
    step(1'b1, 12'h248, 32'h00A0_0050);
    step(1'b1, 12'h248, 32'h0000_0300);
    step(1'b0, 12'h288, '0);
    check(busRdData === 32'h00A0_0350, "R3 set accumulates via clear reg", busRdData, 32'h00A0_0350);

    // R5: partial clear
    step(1'b1, 12'h288, 32'h0000_0310);
    step(1'b0, 12'h248, '0);
    check(busRdData === 32'h00A0_0040, "R5 partial clear", busRdData, 32'h00A0_0040);

    // R8: ring core 3, relock, dropped clear, second pulse once
    step(1'b1, 12'h24C, 32'h0000_0031);
    step(1'b1, 12'h03C, 32'h0);        // R7 relock with wrong key
    step(1'b1, 12'h28C, 32'hFFFF_FFF0);
    step(1'b0, 12'h24C, '0);
    check(coreIrq === 8'h08 && busRdData === 32'h30, "R7 R8 dropped clear repulse", {24'd0, coreIrq}, 32'h8);
    step(1'b1, 12'h28C, 32'hFFFF_FFF0);
    step(1'b0, 12'h24C, '0);
    check(coreIrq === 8'h00, "R8 only once", {24'd0, coreIrq}, 32'h0);

    // R8: accepted full clear gives no second pulse
    unlock();
    step(1'b1, 12'h25C, 32'h0000_0101);
    step(1'b1, 12'h29C, 32'h0000_0100);
    step(1'b0, 12'h25C, '0);
    check(coreIrq === 8'h00 && busRdData === 32'h0, "R8 clean clear", {24'd0, coreIrq}, 32'h0);

    // R9: misaligned and unmapped addresses
    step(1'b1, 12'h241, 32'hFFFF_FFFF);
    step(1'b1, 12'h260, 32'hFFFF_FFFF);
    step(1'b0, 12'h240, '0);
    check(busRdData === 32'h0 && coreIrq === 8'h00, "R9 stray writes", busRdData, 32'h0);
    step(1'b0, 12'h038, '0);
    check(busRdData === 32'h0, "R9 key reads zero", busRdData, 32'h0);

    // Random traffic; R7 relocks mixed in
    for (int n = 0; n < 3000; n++) begin
      int sel = int'($urandom_range(0, 99));
      int core = int'($urandom_range(0, 7));
      logic [31:0] d = $urandom();
      if (sel < 6)       step(1'b1, 12'h038, ($urandom_range(0, 9) < 8) ? KA : d);
      else if (sel < 12) step(1'b1, 12'h03C, ($urandom_range(0, 9) < 8) ? KB : d);
      else if (sel < 45) step(1'b1, 12'h240 + 12'(4*core), d);
      else if (sel < 75) step(1'b1, 12'h280 + 12'(4*core), d);
      else if (sel < 80) step(1'b1, 12'($urandom_range(0, 4095)), d);
      else               step(1'b0, ($urandom_range(0, 1) == 1 ? 12'h240 : 12'h280) + 12'(4*core), '0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule